// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Engine

This block is a 16 x 16 fixed-point multiplier feeding a 48-bit accumulator, operated entirely through a small word-wide register port. Software chooses an operation in an 8-bit control register: plain multiply, multiply-accumulate, multiply-subtract or multiply-negate, each in signed or unsigned form (negate is signed only, which gives seven distinct operations). Software then writes one or two operands. The write that completes the operand set starts the computation, and the 48-bit result can be read as three 16-bit words in the very next cycle.

The operand count sets which write starts the computation. A square option copies operand A into operand B and starts at once. Because no operation takes more than one cycle, a new operand write can follow in every cycle without a stall. A sticky overflow flag records any accumulate or subtract that wrapped the 48-bit range. Self-clearing control bits zero the operands or the accumulator. The three result words are writable, so a starting value can be preloaded into the accumulator.

Top module: `mac48_engine`

## Requirements
- R1: After reset the control register, both operands and all three result words read as zero.
- R2: Register addresses are 0 control, 1 operand A, 2 operand B, 3 result low word (bits 15:0), 4 result middle word (bits 31:16), 5 result high word (bits 47:32); addresses 6 and 7 read zero. Control bits are [1:0] operation (0 multiply, 1 accumulate, 2 subtract, 3 negate), [2] signed, [3] two-operand count, [4] square, [5] overflow flag, [6] clear operands, [7] clear accumulator. Bits 6 and 7 always read back as zero.
- R3: With bit 3 clear, a write to operand A starts the operation, and a write to operand B only loads B.
- R4: With bit 3 set, a write to operand B starts the operation, and a write to operand A only loads A.
- R5: With bit 4 set, a write to operand A also loads that value into operand B and starts the operation, whatever bit 3 holds.
- R6: Unsigned operations: multiply gives A*B zero-extended; accumulate adds it to the accumulator; subtract takes it from the accumulator; code 3 unsigned behaves as plain multiply.
- R7: Signed operations treat operands as two's complement: multiply gives the sign-extended product; negate gives its negation; accumulate and subtract add it to or take it from the accumulator.
- R8: The result of a started operation is readable in the cycle after the starting write, and a starting write in every consecutive cycle is applied each cycle with no stall.
- R9: The overflow flag (control bit 5) is set when an accumulate or subtract wraps the 48-bit range (carry or borrow for unsigned, sign overflow for signed). It is not set by multiply or negate. It stays set until a control write with bit 5 at zero; a control write with bit 5 at one leaves it unchanged.
- R10: A control write with bit 6 set zeroes both operands and keeps the accumulator. A control write with bit 7 set zeroes the accumulator.
- R11: Writing a result word address loads that 16-bit slice of the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the register at addr, combinational |

## Verification
The assertions assume that the port carries at most one register write per cycle and that the operand registers change only through writes to addresses 1 and 2 or a clear-operands command. The unsigned-product property relies on the operand registers holding, one cycle after a start, the very values that were multiplied. The bench drives every write at the falling edge through a single task and holds the strobe for exactly one edge, except in the back-to-back test where it is held for two consecutive edges on purpose. This keeps every start cleanly separated from control writes.

// File: rtl/mac48_pkg.sv
package mac48_pkg;

  // Operation select, control bits [1:0]
  typedef enum logic [1:0] {
    MAC_MUL = 2'd0,
    MAC_ACC = 2'd1,
    MAC_SUB = 2'd2,
    MAC_NEG = 2'd3
  } mac_op_e;

  // Control register bit positions
  localparam int CB_SIGNED  = 2;
  localparam int CB_TWO     = 3;
  localparam int CB_SQUARE  = 4;
  localparam int CB_OVF     = 5;
  localparam int CB_CLR_OPS = 6;
  localparam int CB_CLR_ACC = 7;

  // Register addresses
  localparam int ADR_CTRL = 0;
  localparam int ADR_OPA  = 1;
  localparam int ADR_OPB  = 2;
  localparam int ADR_RES0 = 3;

endpackage

// File: rtl/mac48_ctrl.sv
module mac48_ctrl
  import mac48_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wr_a,
  input  logic       wr_b,
  input  logic [7:0] wbyte,
  input  logic       ovf_event,
  output mac_op_e    cfg_op,
  output logic       cfg_signed,
  output logic       cfg_two,
  output logic       cfg_square,
  output logic       ovf_flag,
  output logic       clr_ops,
  output logic       clr_acc,
  output logic       start_op
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_op     <= MAC_MUL;
      cfg_signed <= 1'b0;
      cfg_two    <= 1'b0;
      cfg_square <= 1'b0;
    end else if (wr_ctrl) begin
      cfg_op     <= mac_op_e'(wbyte[1:0]);
      cfg_signed <= wbyte[CB_SIGNED];
      cfg_two    <= wbyte[CB_TWO];
      cfg_square <= wbyte[CB_SQUARE];
    end
  end

  // Sticky flag: a control write may only keep or clear it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovf_flag <= 1'b0;
    else if (wr_ctrl)
      ovf_flag <= ovf_flag & wbyte[CB_OVF];
    else if (ovf_event)
      ovf_flag <= 1'b1;
  end

  assign clr_ops = wr_ctrl & wbyte[CB_CLR_OPS];
  assign clr_acc = wr_ctrl & wbyte[CB_CLR_ACC];

  // Start decode: square or single-operand mode fires on A, two-operand mode on B
  assign start_op = (wr_a & (cfg_square | ~cfg_two)) |
                    (wr_b & cfg_two & ~cfg_square);

endmodule

// File: rtl/mac48_operands.sv
module mac48_operands #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic          square,
  input  logic          clr_ops,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] b_q,
  output logic [DW-1:0] a_use,
  output logic [DW-1:0] b_use
);

  logic load_b_from_a;
  assign load_b_from_a = wr_a & square;

  // Values seen by the arithmetic in the starting cycle
  assign a_use = wr_a ? wdata : a_q;
  assign b_use = (wr_b | load_b_from_a) ? wdata : b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (clr_ops) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (wr_a)                  a_q <= wdata;
      if (wr_b | load_b_from_a)  b_q <= wdata;
    end
  end

endmodule

// File: rtl/mac48_datapath.sv
module mac48_datapath
  import mac48_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_op,
  input  mac_op_e          op,
  input  logic             is_signed,
  input  logic             clr_acc,
  input  logic [NW-1:0]    wr_word,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    a_use,
  input  logic [DW-1:0]    b_use,
  output logic [NW*DW-1:0] acc_q,
  output logic             ovf_event
);

  localparam int PW   = 2 * DW;
  localparam int ACCW = NW * DW;
  localparam int MSB  = ACCW - 1;

  // Full product extended to accumulator width
  function automatic logic [ACCW-1:0] ext_product(input logic [DW-1:0] a,
                                                  input logic [DW-1:0] b,
                                                  input logic sgn);
    logic [PW-1:0] p;
    if (sgn) begin
      p = PW'($signed({{DW{a[DW-1]}}, a}) * $signed({{DW{b[DW-1]}}, b}));
      return {{(ACCW-PW){p[PW-1]}}, p};
    end else begin
      p = PW'(a) * PW'(b);
      return {{(ACCW-PW){1'b0}}, p};
    end
  endfunction

  // Add or subtract with wrap detection; bit ACCW of the return is the wrap
  function automatic logic [ACCW:0] acc_update(input logic [ACCW-1:0] acc,
                                               input logic [ACCW-1:0] p,
                                               input logic sub,
                                               input logic sgn);
    logic [ACCW:0] w;
    logic          wrap;
    w = sub ? ({1'b0, acc} - {1'b0, p}) : ({1'b0, acc} + {1'b0, p});
    if (sgn)
      wrap = sub ? ((acc[MSB] != p[MSB]) && (w[MSB] != acc[MSB]))
                 : ((acc[MSB] == p[MSB]) && (w[MSB] != acc[MSB]));
    else
      wrap = w[ACCW];
    return {wrap, w[ACCW-1:0]};
  endfunction

  logic [ACCW-1:0] product;
  logic [ACCW:0]   upd;
  logic [ACCW-1:0] acc_d;
  logic            ovf_d;

  assign product = ext_product(a_use, b_use, is_signed);
  assign upd     = acc_update(acc_q, product, (op == MAC_SUB), is_signed);

  always_comb begin
    acc_d = acc_q;
    ovf_d = 1'b0;
    if (clr_acc) begin
      acc_d = '0;
    end else if (start_op) begin
      unique case (op)
        MAC_MUL: acc_d = product;
        MAC_ACC,
        MAC_SUB: begin
          acc_d = upd[ACCW-1:0];
          ovf_d = upd[ACCW];
        end
        MAC_NEG: acc_d = is_signed ? (~product + 1'b1) : product;
        default: acc_d = product;
      endcase
    end else begin
      for (int i = 0; i < NW; i++)
        if (wr_word[i]) acc_d[i*DW +: DW] = wdata;
    end
  end

  assign ovf_event = ovf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

endmodule

// File: rtl/mac48_engine.sv
module mac48_engine
  import mac48_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 3,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int ACCW = NW * DW;

  logic            wr_ctrl, wr_a, wr_b;
  logic [NW-1:0]   wr_word;
  mac_op_e         cfg_op;
  logic            cfg_signed, cfg_two, cfg_square;
  logic            ovf_flag, ovf_event;
  logic            clr_ops, clr_acc, start_op;
  logic [DW-1:0]   a_q, b_q, a_use, b_use;
  logic [ACCW-1:0] acc_q;

  assign wr_ctrl = wr_en && (addr == AW'(ADR_CTRL));
  assign wr_a    = wr_en && (addr == AW'(ADR_OPA));
  assign wr_b    = wr_en && (addr == AW'(ADR_OPB));

  generate
    for (genvar g = 0; g < NW; g++) begin : g_word_wr
      assign wr_word[g] = wr_en && (addr == AW'(ADR_RES0 + g));
    end
  endgenerate

  mac48_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wr_a       (wr_a),
    .wr_b       (wr_b),
    .wbyte      (wdata[7:0]),
    .ovf_event  (ovf_event),
    .cfg_op     (cfg_op),
    .cfg_signed (cfg_signed),
    .cfg_two    (cfg_two),
    .cfg_square (cfg_square),
    .ovf_flag   (ovf_flag),
    .clr_ops    (clr_ops),
    .clr_acc    (clr_acc),
    .start_op   (start_op)
  );

  mac48_operands #(.DW(DW)) u_ops (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_a    (wr_a),
    .wr_b    (wr_b),
    .square  (cfg_square),
    .clr_ops (clr_ops),
    .wdata   (wdata),
    .a_q     (a_q),
    .b_q     (b_q),
    .a_use   (a_use),
    .b_use   (b_use)
  );

  mac48_datapath #(.DW(DW), .NW(NW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_op  (start_op),
    .op        (cfg_op),
    .is_signed (cfg_signed),
    .clr_acc   (clr_acc),
    .wr_word   (wr_word),
    .wdata     (wdata),
    .a_use     (a_use),
    .b_use     (b_use),
    .acc_q     (acc_q),
    .ovf_event (ovf_event)
  );

  always_comb begin
    rdata = '0;
    if (addr == AW'(ADR_CTRL))
      rdata = DW'({ovf_flag, cfg_square, cfg_two, cfg_signed, cfg_op});
    else if (addr == AW'(ADR_OPA))
      rdata = a_q;
    else if (addr == AW'(ADR_OPB))
      rdata = b_q;
    else
      for (int i = 0; i < NW; i++)
        if (addr == AW'(ADR_RES0 + i)) rdata = acc_q[i*DW +: DW];
  end

endmodule

// File: rtl/mac48_checker.sv
module mac48_checker #(
  parameter int DW = 16,
  parameter int NW = 3,
  parameter int AW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic [1:0]       cfg_op,
  input logic             cfg_signed,
  input logic             cfg_square,
  input logic             start_op,
  input logic [DW-1:0]    a_q,
  input logic [DW-1:0]    b_q,
  input logic [NW*DW-1:0] acc_q,
  input logic             ovf_flag,
  input logic             ovf_event
);

  localparam int ACCW = NW * DW;
  localparam int PW   = 2 * DW;

  logic ctrl_wr, opa_wr;
  assign ctrl_wr = wr_en && (addr == AW'(0));
  assign opa_wr  = wr_en && (addr == AW'(1));

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[7]) |=> (acc_q == '0)); // R10

  AST_OPS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[6]) |=> (a_q == '0 && b_q == '0)); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ctrl_wr) |=> ovf_flag); // R9

  AST_OVF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> ovf_flag); // R9

  AST_SQUARE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (opa_wr && cfg_square) |=> (b_q == a_q)); // R5

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(acc_q)); // R8

  AST_UMUL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_op && cfg_op == 2'd0 && !cfg_signed)
      |=> (acc_q == ACCW'(PW'(a_q) * PW'(b_q)))); // R6

endmodule

bind mac48_engine mac48_checker #(.DW(DW), .NW(NW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .cfg_op     (cfg_op),
  .cfg_signed (cfg_signed),
  .cfg_square (cfg_square),
  .start_op   (start_op),
  .a_q        (a_q),
  .b_q        (b_q),
  .acc_q      (acc_q),
  .ovf_flag   (ovf_flag),
  .ovf_event  (ovf_event)
);

// File: tb/test_mac48_engine.sv
`timescale 1ns/1ps
module test_mac48_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mac48_engine i_mac48_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string tag, input logic [47:0] got, input logic [47:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd_acc(output logic [47:0] v);
    logic [15:0] lo, mid, hi;
    rd(3'd3, lo); rd(3'd4, mid); rd(3'd5, hi);
    v = {hi, mid, lo};
  endtask

  task automatic chk_acc(input string tag, input logic [47:0] exp);
    logic [47:0] v;
    rd_acc(v);
    check(tag, v, exp);
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, {32'd0, v}, {32'd0, exp});
  endtask

  task automatic preload(input logic [47:0] v);
    wr(3'd3, v[15:0]); wr(3'd4, v[31:16]); wr(3'd5, v[47:32]);
  endtask

  task automatic t_reset;
    chk_reg("R1 ctrl", 3'd0, 16'h0000);
    chk_reg("R1 opA", 3'd1, 16'h0000);
    chk_reg("R1 opB", 3'd2, 16'h0000);
    chk_acc("R1 result", 48'd0);
  endtask

  task automatic t_regmap;
    wr(3'd0, 16'h00DF);
    chk_reg("R2 ctrl readback drops bits 6,7", 3'd0, 16'h001F);
    chk_reg("R2 unused address", 3'd6, 16'h0000);
    wr(3'd0, 16'h0000);
    chk_reg("R2 ctrl zero", 3'd0, 16'h0000);
  endtask

  task automatic t_count_one;
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd7);
    chk_acc("R3 write B no start", 48'd0);
    wr(3'd1, 16'd6);
    chk_acc("R3 write A starts", 48'd42);
    chk_reg("R2 opA readback", 3'd1, 16'd6);
    chk_reg("R2 opB readback", 3'd2, 16'd7);
  endtask

  task automatic t_count_two;
    wr(3'd0, 16'h0008);
    wr(3'd1, 16'd9);
    chk_acc("R4 write A no start", 48'd42);
    wr(3'd2, 16'd11);
    chk_acc("R4 write B starts", 48'd99);
  endtask

  task automatic t_square;
    wr(3'd0, 16'h0018);
    wr(3'd1, 16'hFFFF);
    chk_reg("R5 B copied from A", 3'd2, 16'hFFFF);
    chk_acc("R5 R6 square of max unsigned", 48'h0000_FFFE_0001);
  endtask

  task automatic t_unsigned;
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'd3);
    chk_acc("R3 B write holds acc", 48'h0000_FFFE_0001);
    wr(3'd1, 16'd4);
    chk_acc("R6 unsigned accumulate", 48'h0000_FFFE_000D);
    wr(3'd0, 16'h0002);
    wr(3'd1, 16'd2);
    chk_acc("R6 unsigned subtract", 48'h0000_FFFE_0007);
    wr(3'd0, 16'h0003);
    wr(3'd1, 16'd5);
    chk_acc("R6 unsigned code 3 plain multiply", 48'd15);
    chk_reg("R9 no overflow yet", 3'd0, 16'h0003);
  endtask

  task automatic t_signed;
    wr(3'd0, 16'h0004);
    wr(3'd2, 16'd2);
    wr(3'd1, 16'hFFFF);
    chk_acc("R7 signed multiply -1*2", 48'hFFFF_FFFF_FFFE);
    wr(3'd2, 16'h8000);
    wr(3'd1, 16'h8000);
    chk_acc("R7 signed min*min", 48'h0000_4000_0000);
    wr(3'd0, 16'h0007);
    wr(3'd2, 16'd5);
    wr(3'd1, 16'd3);
    chk_acc("R7 signed negate", 48'hFFFF_FFFF_FFF1);
    wr(3'd0, 16'h0005);
    wr(3'd1, 16'hFFFF);
    chk_acc("R7 signed accumulate", 48'hFFFF_FFFF_FFEC);
    wr(3'd0, 16'h0006);
    wr(3'd1, 16'hFFFC);
    chk_acc("R7 signed subtract", 48'd0);
    chk_reg("R9 no overflow from signed ops", 3'd0, 16'h0006);
  endtask

  task automatic t_back_to_back;
    wr(3'd0, 16'h0081);
    chk_acc("R10 clear accumulator", 48'd0);
    wr(3'd2, 16'd10);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd1; wdata = 16'd1;
    @(negedge clk);
    wdata = 16'd2;
    @(negedge clk);
    wr_en = 1'b0;
    chk_acc("R8 consecutive starts both applied", 48'd30);
  endtask

  task automatic t_overflow;
    wr(3'd0, 16'h0001);
    preload(48'hFFFF_FFFF_FFFF);
    chk_acc("R11 preload words", 48'hFFFF_FFFF_FFFF);
    wr(3'd2, 16'd1);
    wr(3'd1, 16'd1);
    chk_acc("R9 unsigned carry wraps", 48'd0);
    chk_reg("R9 overflow set", 3'd0, 16'h0021);
    wr(3'd0, 16'h0020);
    wr(3'd1, 16'd3);
    chk_acc("R9 multiply after overflow", 48'd3);
    chk_reg("R9 flag sticky", 3'd0, 16'h0020);
    wr(3'd0, 16'h0000);
    chk_reg("R9 flag cleared", 3'd0, 16'h0000);
    wr(3'd0, 16'h0005);
    preload(48'h7FFF_FFFF_FFFF);
    wr(3'd1, 16'd1);
    chk_acc("R9 signed accumulate wraps", 48'h8000_0000_0000);
    chk_reg("R9 signed overflow set", 3'd0, 16'h0025);
    wr(3'd0, 16'h0006);
    chk_reg("R9 cleared again", 3'd0, 16'h0006);
    wr(3'd1, 16'd1);
    chk_acc("R9 signed subtract wraps", 48'h7FFF_FFFF_FFFF);
    chk_reg("R9 signed borrow set", 3'd0, 16'h0026);
    wr(3'd0, 16'h0082);
    wr(3'd1, 16'd1);
    chk_acc("R9 unsigned borrow wraps", 48'hFFFF_FFFF_FFFF);
    chk_reg("R9 unsigned borrow set", 3'd0, 16'h0022);
  endtask

  task automatic t_clears;
    wr(3'd0, 16'h0040);
    chk_reg("R10 opA cleared", 3'd1, 16'h0000);
    chk_reg("R10 opB cleared", 3'd2, 16'h0000);
    chk_acc("R10 acc kept on operand clear", 48'hFFFF_FFFF_FFFF);
    preload(48'h3333_2222_1111);
    chk_acc("R11 distinct word preload", 48'h3333_2222_1111);
    wr(3'd0, 16'h0080);
    chk_acc("R10 acc cleared", 48'd0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_count_one();
    t_count_two();
    t_square();
    t_unsigned();
    t_signed();
    t_back_to_back();
    t_overflow();
    t_clears();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule